// File: doc/BRIEF.md
# Masked Level-Sensitive Interrupt Controller

This block collects up to 32 level-sensitive interrupt lines from around the chip and turns them into one interrupt request for a processor core. Each line is synchronized into the core's clock domain and kept as a raw level vector. Software controls the block through three control registers. An enable mask chooses which lines may interrupt. A status register holds one global enable bit. A pending view shows which lines are both active and enabled.

The pending view has no storage. It is always the bitwise AND of the synchronized raw lines and the enable mask. The request to the core is a combinational function of registered state. It is high only when the global enable bit is set and at least one line is both raised and unmasked. A write to the status or enable register therefore updates the request in the very next cycle, and no line has to change for that to happen.

Software uses a register port with a 5-bit control-register index. Index 0 is the status register, with the global enable in bit 0. Index 3 is the enable mask. Index 4 is the read-only pending view. Every other index is unimplemented. A read can be flagged as targeting the hardwired-zero destination, and such a read is suppressed.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: A level on an interrupt line is reflected in the stored raw vector after exactly two rising clock edges. Deasserting the line clears its bit after the same two edges.
- R2: A read of index 4 returns the bitwise AND of the raw vector and the enable mask, not the raw lines alone.
- R3: A write to index 4 is ignored: the enable mask, the status register and the pending view keep their values.
- R4: The request output is high exactly when status bit 0 is 1 and the AND of raw vector and enable mask is nonzero.
- R5: A write to index 3 replaces the enable mask, and a write to index 0 updates status bit 0. The request reflects the new value in the cycle after the write, with no line change needed.
- R6: A read flagged as targeting the hardwired-zero destination has no effect: the read-valid flag stays low and the read data holds its previous value.
- R7: After reset the enable mask, the global enable bit, the read data and the request are all zero.
- R8: Reads of indices other than 0, 3 and 4 return zero, and writes to them change no register.
- R9: A read presents its data with the read-valid flag one cycle after the read is issued. The flag is low in the following cycle if no new read is issued. Status reads return the global enable in bit 0 and zeros above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | NUM_LINES | Level-sensitive interrupt lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_rd_zero_i | input | 1 | Read targets the hardwired-zero destination |
| reg_idx_i | input | 5 | Control-register index |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| reg_rvalid_o | output | 1 | Read data valid |
| irq_req_o | output | 1 | Interrupt request to the core |

## Verification
The embedded properties check several behaviours on every cycle:
- the two-stage latency of the raw vector against the lines;
- that pending writes and hardwired-zero reads leave state unchanged;
- that an enable write lands in the mask on the next cycle;
- that unimplemented reads return zero.

Only the bench scenarios can show that the request truly follows the AND of lines and mask for varied patterns, with or without global enable. They also show that unmasking an already-active line raises the request one cycle after the write, and that the whole register map reads back as specified after reset.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int IDX_W   = 5;
  localparam int GIE_BIT = 0;

  typedef enum logic [IDX_W-1:0] {
    IDX_STATUS  = 5'd0,
    IDX_ENABLE  = 5'd3,
    IDX_PENDING = 5'd4
  } lic_idx_e;
endpackage

// File: rtl/lic_rst_sync.sv
module lic_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_ns = stage_q[1];
endmodule

// File: rtl/lic_sync.sv
module lic_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic [WIDTH-1:0] lines_i,
  output logic [WIDTH-1:0] raw_o
);
  logic [WIDTH-1:0] meta_q, raw_q;
  logic [WIDTH-1:0] meta_d, raw_d;

  always_comb begin
    meta_d = lines_i;
    raw_d  = meta_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      meta_q <= '0;
      raw_q  <= '0;
    end else begin
      meta_q <= meta_d;
      raw_q  <= raw_d;
    end
  end

  assign raw_o = raw_q;

  // Count edges since reset so the two-deep look-back stays inside them.
  logic [1:0] seen_q;
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)             seen_q <= 2'd0;
    else if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;
  end

  p_raw_two_edges_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    (seen_q == 2'd2) |-> (raw_q == $past(lines_i, 2)));
endmodule

// File: rtl/lic_req.sv
module lic_req #(
  parameter int N = 32
) (
  input  logic [N-1:0] raw_i,
  input  logic [N-1:0] en_i,
  input  logic         gie_i,
  output logic [N-1:0] pend_o,
  output logic         req_o
);
  always_comb begin
    pend_o = raw_i & en_i;
    req_o  = gie_i & (|pend_o);
  end
endmodule

// File: rtl/lic_regs.sv
module lic_regs
  import lic_pkg::*;
#(
  parameter int N  = 32,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             rd_zero_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [N-1:0]     pend_i,
  output logic [N-1:0]     en_o,
  output logic             gie_o,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o
);
  logic [N-1:0]  en_q, en_d;
  logic          gie_q, gie_d;
  logic [DW-1:0] rdata_q, rdata_d, rd_mux;
  logic          rvalid_q, rvalid_d;
  logic          rd_fire;
  logic          unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_comb begin
    en_d  = en_q;
    gie_d = gie_q;
    if (wr_i) begin
      case (idx_i)
        IDX_ENABLE: en_d  = wdata_i[N-1:0];
        IDX_STATUS: gie_d = wdata_i[GIE_BIT];
        default: ; // pending view and unimplemented indices: discarded
      endcase
    end
  end

  always_comb begin
    case (idx_i)
      IDX_STATUS:  rd_mux = DW'(gie_q);
      IDX_ENABLE:  rd_mux = DW'(en_q);
      IDX_PENDING: rd_mux = DW'(pend_i);
      default:     rd_mux = '0;
    endcase
    rd_fire  = rd_i & ~rd_zero_i;
    rdata_d  = rd_fire ? rd_mux : rdata_q;
    rvalid_d = rd_fire;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      en_q     <= '0;
      gie_q    <= 1'b0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      en_q     <= en_d;
      gie_q    <= gie_d;
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end

  assign en_o     = en_q;
  assign gie_o    = gie_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  p_enable_write_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_i && idx_i == IDX_ENABLE) |=> (en_q == $past(wdata_i[N-1:0])));

  p_pending_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_i && idx_i == IDX_PENDING) |=> ($stable(en_q) && $stable(gie_q)));

  p_unimpl_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd_i && !rd_zero_i && idx_i != IDX_STATUS && idx_i != IDX_ENABLE &&
     idx_i != IDX_PENDING) |=> (rdata_q == '0));

  p_zero_dest_quiet_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd_i && rd_zero_i) |=> (!rvalid_q && $stable(rdata_q)));
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lic_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines_i,
  input  logic                 reg_wr_i,
  input  logic                 reg_rd_i,
  input  logic                 reg_rd_zero_i,
  input  logic [4:0]           reg_idx_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic                 reg_rvalid_o,
  output logic                 irq_req_o
);
  logic                 rst_ns;
  logic [NUM_LINES-1:0] raw, en, pend;
  logic                 gie;

  lic_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  lic_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk(clk), .rst_ns(rst_ns), .lines_i(irq_lines_i), .raw_o(raw)
  );

  lic_req #(.N(NUM_LINES)) u_req (
    .raw_i(raw), .en_i(en), .gie_i(gie), .pend_o(pend), .req_o(irq_req_o)
  );

  lic_regs #(.N(NUM_LINES), .DW(DATA_W)) u_regs (
    .clk(clk), .rst_ns(rst_ns), .wr_i(reg_wr_i), .rd_i(reg_rd_i),
    .rd_zero_i(reg_rd_zero_i), .idx_i(reg_idx_i), .wdata_i(reg_wdata_i),
    .pend_i(pend), .en_o(en), .gie_o(gie), .rdata_o(reg_rdata_o),
    .rvalid_o(reg_rvalid_o)
  );

  p_req_off_after_gie_clear_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (reg_wr_i && reg_idx_i == IDX_STATUS && !reg_wdata_i[GIE_BIT]) |=> !irq_req_o);
endmodule

// File: tb/lvl_irq_ctrl_test.sv
module lvl_irq_ctrl_test;
  typedef struct packed {
    logic [31:0] lines;
    logic [31:0] en;
    logic        gie;
    logic [31:0] pend;
    logic        req;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b0},
    '{32'h0000_0001, 32'h0000_0001, 1'b1, 32'h0000_0001, 1'b1},
    '{32'h8000_0000, 32'h8000_0000, 1'b0, 32'h8000_0000, 1'b0},
    '{32'hA5A5_0F0F, 32'hFF00_FF00, 1'b1, 32'hA500_0F00, 1'b1},
    '{32'h0000_0000, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b0},
    '{32'h1234_5678, 32'hEDCB_A987, 1'b1, 32'h0000_0000, 1'b0},
    '{32'hFFFF_0000, 32'h00FF_FF00, 1'b1, 32'h00FF_0000, 1'b1},
    '{32'h5555_5555, 32'hFFFF_FFFF, 1'b0, 32'h5555_5555, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lines;
  logic        wr, rd, rdz;
  logic [4:0]  idx;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        rvalid, req;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  always #5 clk = ~clk;

  lvl_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_lines_i(lines), .reg_wr_i(wr),
    .reg_rd_i(rd), .reg_rd_zero_i(rdz), .reg_idx_i(idx),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .reg_rvalid_o(rvalid),
    .irq_req_o(req)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic reg_write(input logic [4:0] i, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; idx = i; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] i, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; rdz = 1'b0; idx = i;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
    chk("R9 rvalid on read", {31'b0, rvalid}, 32'd1);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; lines = '1; wr = 0; rd = 0; rdz = 0; idx = 0; wdata = 0;
    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7 req in reset", {31'b0, req}, 32'd0);
    chk("R7 rdata in reset", rdata, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 req after reset", {31'b0, req}, 32'd0);
    reg_read(5'd3, d); chk("R7 enable reset", d, 32'd0);
    reg_read(5'd0, d); chk("R7 status reset", d, 32'd0);
    reg_read(5'd4, d); chk("R2 R7 pending masked at reset", d, 32'd0);

    // Vector table: R2, R4
    for (int v = 0; v < NV; v++) begin
      reg_write(5'd3, TBL[v].en);
      reg_write(5'd0, {31'b0, TBL[v].gie});
      @(negedge clk); lines = TBL[v].lines;
      repeat (3) @(negedge clk);
      chk("R4 request", {31'b0, req}, {31'b0, TBL[v].req});
      reg_read(5'd4, d);
      chk("R2 pending", d, TBL[v].pend);
    end

    // R5: unmasking an active line raises request one cycle after write
    reg_write(5'd3, 32'h0);
    reg_write(5'd0, 32'h1);
    @(negedge clk); lines = 32'h0000_0010;
    repeat (3) @(negedge clk);
    chk("R5 req before unmask", {31'b0, req}, 32'd0);
    reg_write(5'd3, 32'h0000_0010);
    chk("R5 req right after enable write", {31'b0, req}, 32'd1);
    reg_write(5'd0, 32'h0);
    chk("R5 R4 req right after status clear", {31'b0, req}, 32'd0);
    reg_write(5'd0, 32'hFFFF_FFFF);
    chk("R5 req right after status set", {31'b0, req}, 32'd1);
    reg_read(5'd0, d); chk("R9 status only bit0", d, 32'd1);

    // R1: deassert takes exactly two edges
    @(negedge clk); lines = 32'h0;
    @(negedge clk);
    chk("R1 req after one edge", {31'b0, req}, 32'd1);
    @(negedge clk);
    chk("R1 req after two edges", {31'b0, req}, 32'd0);
    @(negedge clk); lines = 32'h0000_0100;
    reg_write(5'd3, 32'h0000_0100);
    chk("R1 req after two edges (assert)", {31'b0, req}, 32'd1);

    // R3: pending writes ignored
    reg_write(5'd3, 32'h0000_00F0);
    @(negedge clk); lines = 32'h0000_00FF;
    repeat (3) @(negedge clk);
    reg_write(5'd4, 32'hFFFF_FFFF);
    reg_read(5'd3, d); chk("R3 enable unchanged", d, 32'h0000_00F0);
    reg_read(5'd4, d); chk("R3 pending unchanged", d, 32'h0000_00F0);
    reg_read(5'd0, d); chk("R3 status unchanged", d, 32'd1);
    reg_write(5'd4, 32'h0);
    chk("R3 req unchanged", {31'b0, req}, 32'd1);

    // R8: unimplemented indices
    reg_write(5'd7, 32'hFFFF_FFFF);
    reg_write(5'd1, 32'h0);
    reg_read(5'd7, d); chk("R8 unimpl read zero", d, 32'd0);
    reg_read(5'd31, d); chk("R8 unimpl read zero idx31", d, 32'd0);
    reg_read(5'd3, d); chk("R8 enable untouched", d, 32'h0000_00F0);
    reg_read(5'd0, d); chk("R8 status untouched", d, 32'd1);

    // R6 / R9: zero-destination read and valid pulse
    reg_read(5'd3, d); chk("R6 setup read", d, 32'h0000_00F0);
    @(negedge clk);
    chk("R9 rvalid drops", {31'b0, rvalid}, 32'd0);
    rd = 1'b1; rdz = 1'b1; idx = 5'd4;
    @(negedge clk);
    rd = 1'b0; rdz = 1'b0;
    chk("R6 no rvalid", {31'b0, rvalid}, 32'd0);
    chk("R6 rdata held", rdata, 32'h0000_00F0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule